// File: doc/BRIEF.md
# Core and Cluster Power-Down Controller

This controller carries out the hardware half of taking one processor core offline. A request names a core and says whether that core is the final active one in its cluster. The controller polls the core's standby-for-interrupt status at a fixed tick interval, with a bounded wait. Once the status is seen, it gates the core's power and lets the supply settle. It then asks the external power-switch ramp logic to switch that core off.

When the request is marked as the last core, the controller continues into a cluster stage. It raises the cluster's snoop-inactive signal so that no coherent traffic reaches the cluster. It polls the shared L2 standby status under the same interval and limit. When that status arrives, it gates the cluster and waits a settle period before it reports completion. If either wait runs out, the operation ends with an error pulse and nothing further changes.

All delays count a free-running `tick` strobe. The poll interval, the timeout and the settle time are parameters expressed in ticks, so the same block serves any reference rate.

Top module: `pdc_ctrl`

## Requirements
- R1: After a synchronous reset, every output is low: all core gates, the switch-off vector, snoop-inactive, the cluster gate, done and error.
- R2: A request is accepted only while idle, and the core index and last-core flag are captured at that moment. A request raised while an operation is in progress has no effect.
- R3: Standby is sampled only at poll points, which come every POLL_TICKS ticks after acceptance. At the first poll point that sees the addressed core's standby bit high, the `core_gate` bit for that core (bit i for core i) is set.
- R4: If the core has shown no standby by TIMEOUT_TICKS ticks after acceptance, `err` pulses. No core gate is set and no switch-off request is issued.
- R5: SETTLE_TICKS ticks after the core gate is set, `sw_off` pulses for one cycle with exactly one bit high: bit i for core i.
- R6: If the request was not marked last, `done` pulses in the same cycle as `sw_off`. Snoop-inactive and the cluster gate stay low.
- R7: If the request was marked last, `snoop_off` rises in the same cycle as `sw_off`. L2 standby is then polled with the same interval and the same limit, counted afresh from that point.
- R8: If L2 standby has not been seen within TIMEOUT_TICKS ticks of the L2 wait, `err` pulses. The cluster gate stays low and snoop-inactive stays high.
- R9: At the first L2 poll point that sees `l2_wfi` high, `cluster_gate` is set. SETTLE_TICKS ticks later, `done` pulses.
- R10: `done` and `err` are single-cycle pulses and are never high together. Each operation produces exactly one of them.
- R11: When standby is first seen on the poll point that coincides with the timeout limit, the standby wins: the gate is set and no error is reported.
- R12: The standby bits of cores other than the addressed one have no effect on the operation.
- R13: Core gates, snoop-inactive and the cluster gate, once set, stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe; all delays count it |
| req | input | 1 | Power-down request, one cycle |
| req_core | input | CORE_W | Index of the core to power down |
| last_core | input | 1 | Request is for the final active core of the cluster |
| core_wfi | input | NUM_CORES | Per-core standby-for-interrupt status |
| l2_wfi | input | 1 | Cluster L2 standby status |
| core_gate | output | NUM_CORES | Per-core power-gate control, 1 = gated |
| sw_off | output | NUM_CORES | One-hot one-cycle request to the switch ramp to turn a core off |
| snoop_off | output | 1 | Cluster snoop-inactive signal |
| cluster_gate | output | 1 | Cluster power-gate control, 1 = gated |
| done | output | 1 | Operation completed, one-cycle pulse |
| err | output | 1 | Operation abandoned on timeout, one-cycle pulse |

## Verification
Standby detection and timeout expiry can fall on the same tick, namely the poll point that ends the allowed window. The bench watches its own tick count during the core wait. It raises the addressed core's standby bit only after the tick just before the limit, so the final poll is the first to see it. Success is judged by the gate being set, a `done` pulse arriving after the settle period with no `err` pulse, and the counted wait being exactly the limit.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORE_WAIT,
    ST_CORE_SETTLE,
    ST_L2_WAIT,
    ST_CL_SETTLE
  } pdc_state_e;
endpackage

// File: rtl/pdc_poller.sv
// Tick-based poll timer: raises hit at a poll point that sees status,
// expire when the window is used up without a hit.
module pdc_poller #(
  parameter int POLL_TICKS    = 4,
  parameter int TIMEOUT_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic status,
  output logic hit,
  output logic expire
);
  localparam int PW = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
  localparam int EW = $clog2(TIMEOUT_TICKS + 1);

  logic [PW-1:0] poll_cnt;
  logic [EW-1:0] elapsed;
  logic          poll_pt;
  logic          at_limit;

  assign poll_pt  = run && tick && (poll_cnt == PW'(POLL_TICKS - 1));
  assign at_limit = run && tick && (elapsed == EW'(TIMEOUT_TICKS - 1));
  assign hit      = poll_pt && status;
  assign expire   = at_limit && !hit;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      poll_cnt <= '0;
      elapsed  <= '0;
    end else if (tick) begin
      poll_cnt <= poll_pt ? '0 : poll_cnt + 1'b1;
      elapsed  <= elapsed + 1'b1;
    end
  end

  // R4
  wait_window_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (elapsed < EW'(TIMEOUT_TICKS)));
endmodule

// File: rtl/pdc_settle.sv
// Counts SETTLE_TICKS ticks while run is high.
module pdc_settle #(
  parameter int SETTLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic fin
);
  localparam int SW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;

  logic [SW-1:0] cnt;

  assign fin = run && tick && (cnt == SW'(SETTLE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pdc_gate_bank.sv
// Sticky per-core power-gate flops.
module pdc_gate_bank #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] set,
  output logic [NUM_CORES-1:0] gate
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst)         gate[i] <= 1'b0;
      else if (set[i]) gate[i] <= 1'b1;
    end

    // R13
    gate_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $past(gate[i]) |-> gate[i]);
  end
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int POLL_TICKS    = 4,
  parameter int TIMEOUT_TICKS = 40,
  parameter int SETTLE_TICKS  = 3,
  parameter int CORE_W        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 req,
  input  logic [CORE_W-1:0]    req_core,
  input  logic                 last_core,
  input  logic [NUM_CORES-1:0] core_wfi,
  input  logic                 l2_wfi,
  output logic [NUM_CORES-1:0] core_gate,
  output logic [NUM_CORES-1:0] sw_off,
  output logic                 snoop_off,
  output logic                 cluster_gate,
  output logic                 done,
  output logic                 err
);
  localparam logic [NUM_CORES-1:0] ONE = NUM_CORES'(1);

  pdc_state_e          state_q;
  logic [CORE_W-1:0]   core_q;
  logic                last_q;
  logic                poll_run, poll_status, poll_hit, poll_expire;
  logic                settle_run, settle_fin;
  logic [NUM_CORES-1:0] core_sel, gate_set;

  assign core_sel    = ONE << core_q;
  assign poll_run    = (state_q == ST_CORE_WAIT) || (state_q == ST_L2_WAIT);
  assign settle_run  = (state_q == ST_CORE_SETTLE) || (state_q == ST_CL_SETTLE);
  assign poll_status = (state_q == ST_L2_WAIT) ? l2_wfi : |(core_wfi & core_sel);
  assign gate_set    = (state_q == ST_CORE_WAIT && poll_hit) ? core_sel : '0;

  pdc_poller #(.POLL_TICKS(POLL_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_poll (
    .clk(clk), .rst(rst), .run(poll_run), .tick(tick),
    .status(poll_status), .hit(poll_hit), .expire(poll_expire)
  );

  pdc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst(rst), .run(settle_run), .tick(tick), .fin(settle_fin)
  );

  pdc_gate_bank #(.NUM_CORES(NUM_CORES)) u_gates (
    .clk(clk), .rst(rst), .set(gate_set), .gate(core_gate)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      core_q       <= '0;
      last_q       <= 1'b0;
      sw_off       <= '0;
      snoop_off    <= 1'b0;
      cluster_gate <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      sw_off <= '0;
      case (state_q)
        ST_IDLE: begin
          if (req) begin
            core_q  <= req_core;
            last_q  <= last_core;
            state_q <= ST_CORE_WAIT;
          end
        end
        ST_CORE_WAIT: begin
          if (poll_hit) begin
            state_q <= ST_CORE_SETTLE;
          end else if (poll_expire) begin
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_CORE_SETTLE: begin
          if (settle_fin) begin
            sw_off <= core_sel;
            if (last_q) begin
              snoop_off <= 1'b1;
              state_q   <= ST_L2_WAIT;
            end else begin
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_L2_WAIT: begin
          if (poll_hit) begin
            cluster_gate <= 1'b1;
            state_q      <= ST_CL_SETTLE;
          end else if (poll_expire) begin
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_CL_SETTLE: begin
          if (settle_fin) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  // R5
  sw_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw_off));
  // R9
  cl_gate_after_l2_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cluster_gate) |-> ($past(snoop_off) && $past(l2_wfi)));
  // R13
  snoop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(snoop_off) |-> snoop_off);
  // R13
  cl_gate_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cluster_gate) |-> cluster_gate);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    // R3
    gate_needs_wfi_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(core_gate[i]) |-> $past(core_wfi[i]));
  end
endmodule

// File: tb/tb_pdc_ctrl.sv
module tb_pdc_ctrl;
  localparam int N  = 4;
  localparam int PT = 4;
  localparam int TO = 40;
  localparam int ST = 3;

  logic         clk = 0, rst = 1, tick = 0, req = 0, last_core = 0, l2_wfi = 0;
  logic [1:0]   req_core = 0;
  logic [N-1:0] core_wfi = 0;
  logic [N-1:0] core_gate, sw_off;
  logic         snoop_off, cluster_gate, done, err;

  pdc_ctrl #(.NUM_CORES(N), .POLL_TICKS(PT), .TIMEOUT_TICKS(TO), .SETTLE_TICKS(ST)) dut (
    .clk(clk), .rst(rst), .tick(tick), .req(req), .req_core(req_core),
    .last_core(last_core), .core_wfi(core_wfi), .l2_wfi(l2_wfi),
    .core_gate(core_gate), .sw_off(sw_off), .snoop_off(snoop_off),
    .cluster_gate(cluster_gate), .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;

  // monitor state
  logic mon_clr = 1;
  logic active;
  logic [1:0] cur;
  logic prev_done, prev_err;
  int c_core, c_cset, c_l2, c_cl, n_done, n_err, n_sw, sw_done, sw_snoop, dbl, both;
  logic [N-1:0] sw_seen;

  initial begin
    forever begin
      @(negedge clk);
      tick = rst ? 1'b0 : ~tick;
    end
  end

  always @(posedge clk) begin
    if (mon_clr) begin
      active <= 0; cur <= 0; prev_done <= 0; prev_err <= 0;
      c_core <= 0; c_cset <= 0; c_l2 <= 0; c_cl <= 0;
      n_done <= 0; n_err <= 0; n_sw <= 0; sw_done <= 0; sw_snoop <= 0;
      dbl <= 0; both <= 0; sw_seen <= 0;
    end else begin
      prev_done <= done; prev_err <= err;
      if ((done && prev_done) || (err && prev_err)) dbl <= dbl + 1;
      if (done && err) both <= both + 1;
      if (done) n_done <= n_done + 1;
      if (err)  n_err  <= n_err + 1;
      if (sw_off != 0) begin
        n_sw <= n_sw + 1;
        sw_seen <= sw_seen | sw_off;
        if (done) sw_done <= sw_done + 1;
        if (snoop_off) sw_snoop <= sw_snoop + 1;
      end
      if (!active && req) begin
        active <= 1; cur <= req_core;
      end else if (active && (done || err)) begin
        active <= 0;
      end
      if (active && !done && !err && tick) begin
        if (!core_gate[cur]) c_core <= c_core + 1;
        if (core_gate[cur] && !snoop_off && sw_off == 0) c_cset <= c_cset + 1;
        if (snoop_off && !cluster_gate) c_l2 <= c_l2 + 1;
        if (cluster_gate) c_cl <= c_cl + 1;
      end
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; req = 0; core_wfi = 0; l2_wfi = 0; last_core = 0; mon_clr = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic start(input int c, input logic last);
    @(negedge clk);
    req = 1; req_core = 2'(c); last_core = last;
    @(negedge clk);
    req = 0; last_core = 0;
  endtask

  task automatic wait_end();
    int k = 0;
    while ((n_done + n_err) == 0 && k < 2000) begin
      @(negedge clk); k++;
    end
    if (k >= 2000) begin
      tests++; fails++;
      $display("FAIL R10: operation hung, actual 0 expected 1 ending pulse");
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 core_gate", int'(core_gate), 0);
    chk("R1 misc", int'({sw_off, snoop_off, cluster_gate, done, err}), 0);
  endtask

  task automatic t_nonlast_fast();
    do_reset();
    core_wfi = 4'b0010;
    start(1, 0);
    wait_end();
    chk("R3 first poll", c_core, PT);
    chk("R3 gate", int'(core_gate), 2);
    chk("R5 settle", c_cset, ST);
    chk("R5 sw onehot", int'(sw_seen), 2);
    chk("R5 sw count", n_sw, 1);
    chk("R6 done with sw", sw_done, 1);
    chk("R6 snoop low", int'(snoop_off), 0);
    chk("R6 cluster low", int'(cluster_gate), 0);
    chk("R10 one done", n_done, 1);
    chk("R10 no err", n_err, 0);
    chk("R10 pulse", dbl + both, 0);
  endtask

  task automatic t_delayed_other();
    do_reset();
    core_wfi = 4'b1001;
    start(2, 0);
    while (c_core < 5) @(negedge clk);
    chk("R12 others ignored", int'(core_gate), 0);
    core_wfi[2] = 1;
    wait_end();
    chk("R3 later poll", c_core, 8);
    chk("R12 gate only addressed", int'(core_gate), 4);
    chk("R5 sw core2", int'(sw_seen), 4);
    chk("R10 done", n_done, 1);
  endtask

  task automatic t_core_timeout();
    do_reset();
    core_wfi = 4'b0111;
    start(3, 1);
    wait_end();
    chk("R4 window", c_core, TO);
    chk("R4 err", n_err, 1);
    chk("R4 no done", n_done, 0);
    chk("R4 no gate", int'(core_gate), 0);
    chk("R4 no sw", n_sw, 0);
    chk("R4 snoop low", int'(snoop_off), 0);
    chk("R10 pulse", dbl + both, 0);
  endtask

  task automatic t_last_ok();
    do_reset();
    core_wfi = 4'b0010;
    start(1, 1);
    while (c_l2 < 9) @(negedge clk);
    chk("R7 snoop up", int'(snoop_off), 1);
    chk("R9 cluster not yet", int'(cluster_gate), 0);
    l2_wfi = 1;
    wait_end();
    chk("R7 sw with snoop", sw_snoop, 1);
    chk("R7 no early done", sw_done, 0);
    chk("R7 l2 poll", c_l2, 12);
    chk("R9 cluster gate", int'(cluster_gate), 1);
    chk("R9 settle", c_cl, ST);
    chk("R9 done", n_done, 1);
    chk("R13 snoop held", int'(snoop_off), 1);
    chk("R13 core gate held", int'(core_gate), 2);
  endtask

  task automatic t_l2_timeout();
    do_reset();
    core_wfi = 4'b0001;
    start(0, 1);
    wait_end();
    chk("R8 window", c_l2, TO);
    chk("R8 err", n_err, 1);
    chk("R8 no done", n_done, 0);
    chk("R8 cluster low", int'(cluster_gate), 0);
    chk("R8 snoop stays", int'(snoop_off), 1);
    chk("R8 core gated", int'(core_gate), 1);
  endtask

  task automatic t_final_poll();
    do_reset();
    start(0, 0);
    while (c_core < TO - 1) @(negedge clk);
    core_wfi[0] = 1;
    wait_end();
    chk("R11 window", c_core, TO);
    chk("R11 no err", n_err, 0);
    chk("R11 done", n_done, 1);
    chk("R11 gate", int'(core_gate), 1);
  endtask

  task automatic t_busy_req();
    do_reset();
    start(0, 0);
    repeat (6) @(negedge clk);
    core_wfi[3] = 1;
    start(3, 1);
    repeat (4) @(negedge clk);
    chk("R2 ignored gate", int'(core_gate), 0);
    core_wfi[0] = 1;
    wait_end();
    chk("R2 gate first core", int'(core_gate), 1);
    chk("R2 last ignored", int'(snoop_off), 0);
    chk("R2 one done", n_done, 1);
    chk("R2 sw core0", int'(sw_seen), 1);
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_nonlast_fast();
    t_delayed_other();
    t_core_timeout();
    t_last_ok();
    t_l2_timeout();
    t_final_poll();
    t_busy_req();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule